// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block sits between a bit-level UART receiver and a CPU read port. It holds the receive data register and five status flags: data-full, overrun, noise, framing error and parity error. The receiver hands over each completed byte together with its noise, framing and parity indications. The block loads the byte into the data register only when that register is free. Otherwise it drops the byte and records an overrun. The data register keeps the older byte, which has not been read yet.

Software clears flags with a two-step read. A status read records ("arms") each flag that it saw set. A following data read clears exactly the armed flags. A flag that becomes set after the status read therefore survives that data read. Software can then read the status register a second time and learn whether a byte was lost while the previous one was being handled. Interrupt outputs are the flags gated by per-source enable inputs.

Top module: `uart_rx_status`

## Requirements
- R1: After reset every flag is clear, `rd_data` is zero and both interrupt outputs are low.
- R2: A byte offered with `rx_valid` while data-full is clear is loaded into the data register, and data-full (status bit 5) reads as set from the next cycle.
- R3: A byte offered while data-full is set, and not cleared in that same cycle, is discarded. Overrun (status bit 3) becomes set, and the data register keeps the earlier byte.
- R4: A status read followed by a data read clears data-full. A data read with no earlier status read returns the byte but clears no flag.
- R5: Noise (bit 2), framing (bit 1) and parity (bit 0) are set from the indications that come with an accepted byte. The indications of a discarded byte have no effect.
- R6: A data read clears only the flags that the latest status read saw set. A flag set after that status read stays set until a new status-then-data sequence.
- R7: An overrun that occurs between the status read and the data read is visible in a second status read made after the data read.
- R8: If a byte arrives in the same cycle as a data read that clears data-full, the byte is accepted and data-full stays set. The read returns the earlier byte.
- R9: `irq_rx` is data-full AND `en_full_irq`. `irq_err` is the OR of noise, framing and parity, each ANDed with its own enable.
- R10: A read with `rd_en` high returns the selected register on `rd_data` one cycle later (`rd_sel`=0 status, 1 data). Status bits 7, 6 and 4 read as zero, and `rd_data` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver has a completed byte this cycle |
| rx_byte | input | DW | Completed byte |
| rx_noise | input | 1 | Noise seen while the byte was received |
| rx_frame_err | input | 1 | Stop bit was sampled as 0 |
| rx_parity_err | input | 1 | Parity check failed |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_sel | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | DW | Registered read result |
| en_full_irq | input | 1 | Enable for the data-full interrupt |
| en_noise_irq | input | 1 | Enable for noise in `irq_err` |
| en_frame_irq | input | 1 | Enable for framing error in `irq_err` |
| en_parity_irq | input | 1 | Enable for parity error in `irq_err` |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
A byte or a read presented at a rising edge takes effect on the flags and the data register at that same edge. The read result appears on `rd_data` just after that edge. The interrupt outputs are combinational on the flags, so they follow in the same cycle as the flag change. The bench drives each stimulus at a falling edge and holds it across exactly one rising edge. It samples one time unit after that edge, which is the first point where both the read result and the updated flags are settled.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    // flag vector indices (internal)
    localparam int FLAG_N  = 5;
    localparam int F_PAR   = 0;
    localparam int F_FRAME = 1;
    localparam int F_NOISE = 2;
    localparam int F_OVR   = 3;
    localparam int F_FULL  = 4;

    // status register bit positions (software visible)
    localparam int STS_PAR   = 0;
    localparam int STS_FRAME = 1;
    localparam int STS_NOISE = 2;
    localparam int STS_OVR   = 3;
    localparam int STS_FULL  = 5;
    localparam int STS_MIN_W = 6;

    typedef logic [FLAG_N-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
        flag_vec_t arm;
    } flag_state_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } rd_sel_e;

endpackage

// File: rtl/rxs_flag_ctrl.sv
module rxs_flag_ctrl
    import uart_rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_valid,
    input  logic      rx_noise,
    input  logic      rx_frame_err,
    input  logic      rx_parity_err,
    input  logic      rd_status,
    input  logic      rd_datareg,
    output logic      accept,
    output flag_vec_t flags
);

    flag_state_t st_d, st_q;
    flag_vec_t   clr_mask;
    flag_vec_t   set_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = rd_datareg ? st_q.arm : '0;
        accept   = rx_valid && (!st_q.flags[F_FULL] || clr_mask[F_FULL]);

        set_mask          = '0;
        set_mask[F_FULL]  = accept;
        set_mask[F_OVR]   = rx_valid && !accept;
        set_mask[F_NOISE] = accept && rx_noise;
        set_mask[F_FRAME] = accept && rx_frame_err;
        set_mask[F_PAR]   = accept && rx_parity_err;

        // a set wins over a clear in the same cycle
        st_d.flags = set_mask | (st_q.flags & ~clr_mask);

        if (rd_status) begin
            st_d.arm = st_q.flags;
        end else if (rd_datareg) begin
            st_d.arm = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q.flags[F_FULL] && !(rd_datareg && st_q.arm[F_FULL]))
        |=> st_q.flags[F_OVR]);

    // R4
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_datareg && st_q.arm[F_FULL] && !rx_valid) |=> !st_q.flags[F_FULL]);

    // R6
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_datareg && st_q.flags[F_NOISE] && !st_q.arm[F_NOISE])
        |=> st_q.flags[F_NOISE]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rd_datareg && st_q.arm[F_FULL]) |=> st_q.flags[F_FULL]);

endmodule

// File: rtl/rxs_data_reg.sv
module rxs_data_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          accept,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] data
);

    typedef struct packed {
        logic [DW-1:0] byte_val;
    } data_state_t;

    data_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.byte_val = rx_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.byte_val;

    // R3
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !accept) |=> $stable(data));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (data == $past(rx_byte)));

endmodule

// File: rtl/rxs_readback.sv
module rxs_readback
    import uart_rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_sel,
    input  flag_vec_t     flags,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic [DW-1:0] word;
    } rb_state_t;

    rb_state_t     st_d, st_q;
    logic [DW-1:0] status_word;

    always_comb begin
        status_word            = '0;
        status_word[STS_FULL]  = flags[F_FULL];
        status_word[STS_OVR]   = flags[F_OVR];
        status_word[STS_NOISE] = flags[F_NOISE];
        status_word[STS_FRAME] = flags[F_FRAME];
        status_word[STS_PAR]   = flags[F_PAR];

        st_d = st_q;
        if (rd_en) begin
            st_d.word = (rd_sel == SEL_DATA) ? data : status_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.word;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R10
    rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel) |=> (rd_data == $past(data)));

endmodule

// File: rtl/rxs_irq_gate.sv
module rxs_irq_gate
    import uart_rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t flags,
    input  logic      en_full_irq,
    input  logic      en_noise_irq,
    input  logic      en_frame_irq,
    input  logic      en_parity_irq,
    output logic      irq_rx,
    output logic      irq_err
);

    always_comb begin
        irq_rx  = flags[F_FULL] && en_full_irq;
        irq_err = (flags[F_NOISE] && en_noise_irq)
               || (flags[F_FRAME] && en_frame_irq)
               || (flags[F_PAR]   && en_parity_irq);
    end

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_noise_irq && !en_frame_irq && !en_parity_irq) |-> !irq_err);

    // R9
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_full_irq |-> !irq_rx);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_noise,
    input  logic          rx_frame_err,
    input  logic          rx_parity_err,
    input  logic          rd_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          en_full_irq,
    input  logic          en_noise_irq,
    input  logic          en_frame_irq,
    input  logic          en_parity_irq,
    output logic          irq_rx,
    output logic          irq_err
);

    localparam bit DW_OK = (DW >= STS_MIN_W);

    logic          rd_status;
    logic          rd_datareg;
    logic          accept;
    flag_vec_t     flags;
    logic [DW-1:0] data;

    assign rd_status  = rd_en && (rd_sel == SEL_STATUS);
    assign rd_datareg = rd_en && (rd_sel == SEL_DATA);

    rxs_flag_ctrl u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_noise      (rx_noise),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err),
        .rd_status     (rd_status),
        .rd_datareg    (rd_datareg),
        .accept        (accept),
        .flags         (flags)
    );

    rxs_data_reg #(.DW(DW)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .accept   (accept),
        .rx_byte  (rx_byte),
        .data     (data)
    );

    rxs_readback #(.DW(DW)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .flags   (flags),
        .data    (data),
        .rd_data (rd_data)
    );

    rxs_irq_gate u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .flags         (flags),
        .en_full_irq   (en_full_irq),
        .en_noise_irq  (en_noise_irq),
        .en_frame_irq  (en_frame_irq),
        .en_parity_irq (en_parity_irq),
        .irq_rx        (irq_rx),
        .irq_err       (irq_err)
    );

    // R10
    width_chk: assert property (@(posedge clk) disable iff (!rst_n) DW_OK);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq_rx && !irq_err));

endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_noise = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       rx_parity_err = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       en_full_irq = 1'b0;
    logic       en_noise_irq = 1'b0;
    logic       en_frame_irq = 1'b0;
    logic       en_parity_irq = 1'b0;
    logic       irq_rx;
    logic       irq_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    localparam logic [7:0] B_FULL  = 8'h20;
    localparam logic [7:0] B_OVR   = 8'h08;
    localparam logic [7:0] B_NOISE = 8'h04;
    localparam logic [7:0] B_FRAME = 8'h02;
    localparam logic [7:0] B_PAR   = 8'h01;

    always #2 clk = ~clk;

    uart_rx_status #(.DW(8)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_noise      (rx_noise),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err),
        .rd_en         (rd_en),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .en_full_irq   (en_full_irq),
        .en_noise_irq  (en_noise_irq),
        .en_frame_irq  (en_frame_irq),
        .en_parity_irq (en_parity_irq),
        .irq_rx        (irq_rx),
        .irq_err       (irq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic n, input logic f, input logic p);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        rx_noise = n; rx_frame_err = f; rx_parity_err = p;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_noise = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(posedge clk);
        #1;
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq_rx", {7'b0, irq_rx}, 8'h00);
        check("R1 irq_err", {7'b0, irq_err}, 8'h00);
        begin
            logic [7:0] v;
            rd(1'b0, v);
            check("R1 status", v, 8'h00);
        end
    endtask

    task automatic t_basic();
        logic [7:0] v;
        send(8'hA5, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R2 R10 status full", v, B_FULL);
        rd(1'b1, v); check("R2 data", v, 8'hA5);
        rd(1'b0, v); check("R4 cleared", v, 8'h00);
        repeat (3) @(posedge clk);
        #1 check("R10 hold", rd_data, 8'h00);
    endtask

    task automatic t_no_arm();
        logic [7:0] v;
        send(8'h11, 1'b0, 1'b0, 1'b0);
        rd(1'b1, v); check("R4 data without status", v, 8'h11);
        rd(1'b0, v); check("R4 full kept", v, B_FULL);
        rd(1'b1, v);
        rd(1'b0, v); check("R4 cleared after sequence", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send(8'h21, 1'b0, 1'b0, 1'b0);
        send(8'h42, 1'b1, 1'b1, 1'b1);
        rd(1'b0, v); check("R3 R5 overrun, dropped errors ignored", v, B_FULL | B_OVR);
        rd(1'b1, v); check("R3 data kept", v, 8'h21);
        rd(1'b0, v); check("R3 overrun cleared", v, 8'h00);
    endtask

    task automatic t_late_overrun();
        logic [7:0] v;
        send(8'h31, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R7 first status", v, B_FULL);
        send(8'h32, 1'b0, 1'b0, 1'b0);
        rd(1'b1, v); check("R7 data is first byte", v, 8'h31);
        rd(1'b0, v); check("R7 second status shows overrun", v, B_OVR);
        rd(1'b1, v);
        rd(1'b0, v); check("R6 overrun cleared by new sequence", v, 8'h00);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        send(8'h33, 1'b0, 1'b1, 1'b1);
        rd(1'b0, v); check("R5 frame parity", v, B_FULL | B_FRAME | B_PAR);
        rd(1'b1, v); check("R5 data", v, 8'h33);
        rd(1'b0, v); check("R5 cleared", v, 8'h00);
        send(8'h44, 1'b1, 1'b0, 1'b0);
        rd(1'b0, v); check("R5 noise", v, B_FULL | B_NOISE);
        rd(1'b1, v);
        rd(1'b0, v); check("R5 noise cleared", v, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        send(8'h51, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R8 status", v, B_FULL);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 1'b1;
        rx_valid = 1'b1; rx_byte = 8'h52; rx_parity_err = 1'b1;
        @(posedge clk);
        #1;
        v = rd_data;
        rd_en = 1'b0; rx_valid = 1'b0; rx_parity_err = 1'b0;
        check("R8 read returns earlier byte", v, 8'h51);
        rd(1'b1, v); check("R6 unarmed data read", v, 8'h52);
        rd(1'b0, v); check("R8 R6 full and parity kept", v, B_FULL | B_PAR);
        rd(1'b1, v); check("R8 new byte", v, 8'h52);
        rd(1'b0, v); check("R6 cleared", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        send(8'h61, 1'b1, 1'b1, 1'b0);
        check("R9 rx masked", {7'b0, irq_rx}, 8'h00);
        check("R9 err masked", {7'b0, irq_err}, 8'h00);
        en_full_irq = 1'b1; #1;
        check("R9 rx enabled", {7'b0, irq_rx}, 8'h01);
        en_noise_irq = 1'b1; #1;
        check("R9 noise enabled", {7'b0, irq_err}, 8'h01);
        en_noise_irq = 1'b0; en_frame_irq = 1'b1; #1;
        check("R9 frame enabled", {7'b0, irq_err}, 8'h01);
        en_frame_irq = 1'b0; en_parity_irq = 1'b1; #1;
        check("R9 parity only, no parity flag", {7'b0, irq_err}, 8'h00);
        en_noise_irq = 1'b1; en_frame_irq = 1'b1;
        rd(1'b0, v);
        rd(1'b1, v);
        check("R9 rx after clear", {7'b0, irq_rx}, 8'h00);
        check("R9 err after clear", {7'b0, irq_err}, 8'h00);
        en_full_irq = 1'b0; en_noise_irq = 1'b0;
        en_frame_irq = 1'b0; en_parity_irq = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_no_arm();
        t_overrun();
        t_late_overrun();
        t_errors();
        t_same_cycle();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule